// File: doc/BRIEF.md
# Split-Bank Sense Amp Conflict Tracker

This block follows the open or closed state of every bank in a DRAM core whose sense amps are shared between neighbouring banks. A controller feeds it the same row and column commands it sends to the device. The block flags an activate that would collide with a bank already holding the shared sense amps. It keeps the open row of every bank, so the scheduler can check a row hit before it issues a column command.

There are three inputs: a row channel (activate or precharge, with a bank and a 9-bit row), a column channel (read, write or no-op, each with or without auto-precharge, plus the byte-mask flag of a write), and an extended-precharge strobe with its own bank. Every command takes effect at the clock edge on which it is presented. Legality is judged on the state held before that edge. Error flags are registered one-cycle pulses.

Each bank shares its sense amps with both of its neighbours, with two exceptions. The banks at the outer ends have no outer neighbour. The two halves of the core are split between bank SPLIT-1 and bank SPLIT (15 and 16 by default), and no sense amp crosses that split.

Top module: `sa_bank_tracker`

## Requirements
- R1: After reset every bank is closed, `open_o` is zero, both error outputs are low and `query_row_o` is zero.
- R2: An activate (`row_op_i` = 01) to a closed bank whose sharing neighbours are closed sets that bank's `open_o` bit on the following cycle. `query_row_o` then returns the row given with the activate.
- R3: An activate to a bank that is already open pulses `err_act_o` high for one cycle. The open flags and the stored row are left unchanged.
- R4: An activate to a bank whose lower or upper sharing neighbour is open pulses `err_act_o` and opens nothing. Two sharing neighbours are never open together.
- R5: Banks SPLIT-1 and SPLIT (15 and 16) do not share sense amps and may be open together. Bank 0 and the last bank may also be open together.
- R6: A precharge (`row_op_i` = 10) closes the named bank, after which a neighbour or a new row may be activated. A precharge to a closed bank changes nothing and raises no error.
- R7: The column commands with auto-precharge close the named bank: read with precharge (101), write with precharge (110) and no-op with precharge (111).
- R8: A plain read (001), plain write (010) or plain no-op (011) leaves the bank open.
- R9: An extended precharge closes its bank when the most recent column command was a read (001 or 101) or a write (010 or 110) with `col_mask_i` = 0. Idle column cycles (000) do not change this condition.
- R10: An extended precharge is rejected and pulses `err_xpre_o` in three cases: after a masked write, after a no-op, or before any column command since reset. The bank's state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_op_i | input | 2 | Row command: 00 idle, 01 activate, 10 precharge |
| row_bank_i | input | 5 | Bank of the row command |
| row_addr_i | input | 9 | Row loaded by an activate |
| col_op_i | input | 3 | Column command; bit 2 selects auto-precharge |
| col_bank_i | input | 5 | Bank of the column command |
| col_mask_i | input | 1 | Byte-mask flag of a write |
| xpre_i | input | 1 | Extended precharge strobe |
| xpre_bank_i | input | 5 | Bank of the extended precharge |
| query_bank_i | input | 5 | Bank whose row is reported |
| open_o | output | 32 | Per-bank open flags |
| query_open_o | output | 1 | Open flag of the queried bank |
| query_row_o | output | 9 | Open row of the queried bank, zero when closed |
| err_act_o | output | 1 | Pulse: rejected activate |
| err_xpre_o | output | 1 | Pulse: rejected extended precharge |

## Verification
Some properties hold on every cycle, and the assertions watch these. No two sharing neighbours are open together. At most one bank opens per cycle, and only after an activate. A bank closes only after one of the three close paths. An error pulse leaves no bank newly opened. Other behaviour can only be shown by the bench's scenarios. These include the stored row being returned, the split and end banks coexisting, a redundant precharge staying silent, and extended-precharge eligibility following the last column command through masked writes, no-ops and idle cycles.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    ROW_IDLE = 2'b00,
    ROW_ACT  = 2'b01,
    ROW_PRE  = 2'b10,
    ROW_RSVD = 2'b11
  } row_op_e;

  // bit 2 marks auto-precharge; 100 is not a command
  typedef enum logic [2:0] {
    COL_IDLE = 3'b000,
    COL_RD   = 3'b001,
    COL_WR   = 3'b010,
    COL_NOP  = 3'b011,
    COL_RSVD = 3'b100,
    COL_RDA  = 3'b101,
    COL_WRA  = 3'b110,
    COL_NOPA = 3'b111
  } col_op_e;
endpackage

// File: rtl/sat_conflict_map.sv
module sat_conflict_map #(
  parameter int NUM_BANKS = 32,
  parameter int SPLIT     = NUM_BANKS / 2
) (
  input  logic [NUM_BANKS-1:0] open_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic lo_hit, hi_hit;
    if (b > 0 && b != SPLIT) begin : g_lo
      assign lo_hit = open_i[b-1];
    end else begin : g_lo_none
      assign lo_hit = 1'b0;
    end
    if (b < NUM_BANKS - 1 && b != SPLIT - 1) begin : g_hi
      assign hi_hit = open_i[b+1];
    end else begin : g_hi_none
      assign hi_hit = 1'b0;
    end
    assign busy_o[b] = open_i[b] | lo_hit | hi_hit;
  end
endmodule

// File: rtl/sat_close_path.sv
module sat_close_path
  import sat_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  row_op_e              row_op_i,
  input  logic [BANK_W-1:0]    row_bank_i,
  input  col_op_e              col_op_i,
  input  logic [BANK_W-1:0]    col_bank_i,
  input  logic                 col_mask_i,
  input  logic                 xpre_i,
  input  logic [BANK_W-1:0]    xpre_bank_i,
  output logic [NUM_BANKS-1:0] close_o,
  output logic                 xpre_rej_o
);
  logic xpre_ok_q;
  logic col_auto, col_cmd, col_arm, xpre_go;

  always_comb begin
    col_auto   = col_op_i inside {COL_RDA, COL_WRA, COL_NOPA};
    col_cmd    = !(col_op_i inside {COL_IDLE, COL_RSVD});
    col_arm    = (col_op_i inside {COL_RD, COL_RDA}) ||
                 ((col_op_i inside {COL_WR, COL_WRA}) && !col_mask_i);
    xpre_go    = xpre_i && xpre_ok_q;
    xpre_rej_o = xpre_i && !xpre_ok_q;
  end

  // eligibility follows the most recent real column command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      xpre_ok_q <= 1'b0;
    else if (col_cmd) xpre_ok_q <= col_arm;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_close
    assign close_o[b] = (row_op_i == ROW_PRE && row_bank_i == BANK_W'(b)) ||
                        (col_auto && col_bank_i == BANK_W'(b)) ||
                        (xpre_go && xpre_bank_i == BANK_W'(b));
  end
endmodule

// File: rtl/sat_bank_file.sv
module sat_bank_file #(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W     = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] set_i,
  input  logic [NUM_BANKS-1:0] close_i,
  input  logic [ROW_W-1:0]     row_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [ROW_W-1:0]     rows_o [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (set_i[b]) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (close_i[b]) begin
        open_q <= 1'b0;
      end
    end
    assign open_o[b] = open_q;
    assign rows_o[b] = row_q;
  end
endmodule

// File: rtl/sa_bank_tracker.sv
module sa_bank_tracker
  import sat_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W     = 9,
  parameter int SPLIT     = NUM_BANKS / 2,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           row_op_i,
  input  logic [BANK_W-1:0]    row_bank_i,
  input  logic [ROW_W-1:0]     row_addr_i,
  input  logic [2:0]           col_op_i,
  input  logic [BANK_W-1:0]    col_bank_i,
  input  logic                 col_mask_i,
  input  logic                 xpre_i,
  input  logic [BANK_W-1:0]    xpre_bank_i,
  input  logic [BANK_W-1:0]    query_bank_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 query_open_o,
  output logic [ROW_W-1:0]     query_row_o,
  output logic                 err_act_o,
  output logic                 err_xpre_o
);
  row_op_e              row_op;
  col_op_e              col_op;
  logic [NUM_BANKS-1:0] busy, set_vec, close_vec;
  logic [ROW_W-1:0]     rows [NUM_BANKS];
  logic                 act, act_bad, xpre_rej;
  logic                 err_act_q, err_xpre_q;

  assign row_op = row_op_e'(row_op_i);
  assign col_op = col_op_e'(col_op_i);

  sat_conflict_map #(.NUM_BANKS(NUM_BANKS), .SPLIT(SPLIT)) u_map (
    .open_i (open_o),
    .busy_o (busy)
  );

  sat_close_path #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_close (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_op_i    (row_op),
    .row_bank_i  (row_bank_i),
    .col_op_i    (col_op),
    .col_bank_i  (col_bank_i),
    .col_mask_i  (col_mask_i),
    .xpre_i      (xpre_i),
    .xpre_bank_i (xpre_bank_i),
    .close_o     (close_vec),
    .xpre_rej_o  (xpre_rej)
  );

  // legality is judged on pre-edge state
  always_comb begin
    act     = (row_op == ROW_ACT);
    act_bad = act && busy[row_bank_i];
    set_vec = (act && !act_bad) ? (NUM_BANKS'(1) << row_bank_i) : '0;
  end

  sat_bank_file #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .close_i (close_vec),
    .row_i   (row_addr_i),
    .open_o  (open_o),
    .rows_o  (rows)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_act_q  <= 1'b0;
      err_xpre_q <= 1'b0;
    end else begin
      err_act_q  <= act_bad;
      err_xpre_q <= xpre_rej;
    end
  end

  assign err_act_o    = err_act_q;
  assign err_xpre_o   = err_xpre_q;
  assign query_open_o = open_o[query_bank_i];
  assign query_row_o  = query_open_o ? rows[query_bank_i] : '0;
endmodule

// File: rtl/sat_tracker_chk.sv
module sat_tracker_chk #(
  parameter int NUM_BANKS = 32,
  parameter int SPLIT     = NUM_BANKS / 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           row_op_i,
  input logic [2:0]           col_op_i,
  input logic                 xpre_i,
  input logic [NUM_BANKS-1:0] open_o,
  input logic                 err_act_o,
  input logic                 err_xpre_o
);
  for (genvar b = 0; b < NUM_BANKS - 1; b++) begin : g_pair
    if (b != SPLIT - 1) begin : g_shared
      // R4
      pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(open_o[b] && open_o[b+1]));
    end
  end

  // R2
  open_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((open_o & ~$past(open_o)) != '0) |-> ($past(row_op_i) == 2'b01));

  // R2
  single_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(open_o & ~$past(open_o)) <= 1);

  // R3
  act_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_act_o |-> ((open_o & ~$past(open_o)) == '0) && ($past(row_op_i) == 2'b01));

  // R6
  close_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~open_o & $past(open_o)) != '0) |->
      ($past(row_op_i) == 2'b10 || $past(col_op_i[2]) || $past(xpre_i)));

  // R10
  xpre_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_xpre_o |-> $past(xpre_i));
endmodule

bind sa_bank_tracker sat_tracker_chk #(.NUM_BANKS(NUM_BANKS), .SPLIT(SPLIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .row_op_i   (row_op_i),
  .col_op_i   (col_op_i),
  .xpre_i     (xpre_i),
  .open_o     (open_o),
  .err_act_o  (err_act_o),
  .err_xpre_o (err_xpre_o)
);

// File: tb/sa_bank_tracker_bench.sv
`timescale 1ns/1ps
module sa_bank_tracker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  row_op_i = 2'b00;
  logic [4:0]  row_bank_i = '0;
  logic [8:0]  row_addr_i = '0;
  logic [2:0]  col_op_i = 3'b000;
  logic [4:0]  col_bank_i = '0;
  logic        col_mask_i = 1'b0;
  logic        xpre_i = 1'b0;
  logic [4:0]  xpre_bank_i = '0;
  logic [4:0]  query_bank_i = '0;
  logic [31:0] open_o;
  logic        query_open_o;
  logic [8:0]  query_row_o;
  logic        err_act_o, err_xpre_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] open;
    logic        eact;
    logic        exp_x;
    logic        qopen;
    logic [8:0]  qrow;
  } item_t;
  item_t sb_q[$];

  bit         m_open[32];
  logic [8:0] m_row[32];
  bit         m_elig = 0;

  always #2 clk_i = ~clk_i;

  sa_bank_tracker u_sa_bank_tracker (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [1:0] rop, int rb, logic [8:0] ra,
                       logic [2:0] cop, int cb, bit cm, bit xp, int xb, int qb);
    item_t it;
    bit busy, cmd;
    bit cl[32];
    @(negedge clk_i);
    row_op_i = rop; row_bank_i = 5'(rb); row_addr_i = ra;
    col_op_i = cop; col_bank_i = 5'(cb); col_mask_i = cm;
    xpre_i = xp; xpre_bank_i = 5'(xb); query_bank_i = 5'(qb);
    foreach (cl[i]) cl[i] = 0;
    busy = m_open[rb] || (rb > 0 && rb != 16 && m_open[rb-1]) ||
           (rb < 31 && rb != 15 && m_open[rb+1]);
    it.tag  = tag;
    it.eact = (rop == 2'b01) && busy;
    it.exp_x = xp && !m_elig;
    if (rop == 2'b10) cl[rb] = 1;
    if (cop inside {3'b101, 3'b110, 3'b111}) cl[cb] = 1;
    if (xp && m_elig) cl[xb] = 1;
    cmd = !(cop inside {3'b000, 3'b100});
    if (cmd) m_elig = (cop == 3'b001 || cop == 3'b101) ||
                      ((cop == 3'b010 || cop == 3'b110) && !cm);
    foreach (cl[i]) if (cl[i]) m_open[i] = 0;
    if (rop == 2'b01 && !busy) begin
      m_open[rb] = 1;
      m_row[rb]  = ra;
    end
    foreach (m_open[i]) it.open[i] = m_open[i];
    it.qopen = m_open[qb];
    it.qrow  = m_open[qb] ? m_row[qb] : 9'h0;
    sb_q.push_back(it);
  endtask

  task automatic act(string tag, int b, logic [8:0] r);
    drive(tag, 2'b01, b, r, 3'b000, 0, 0, 0, 0, b);
  endtask
  task automatic pre(string tag, int b);
    drive(tag, 2'b10, b, 0, 3'b000, 0, 0, 0, 0, b);
  endtask
  task automatic col(string tag, logic [2:0] op, int b, bit m);
    drive(tag, 2'b00, 0, 0, op, b, m, 0, 0, b);
  endtask
  task automatic xpre(string tag, int b);
    drive(tag, 2'b00, 0, 0, 3'b000, 0, 0, 1, b, b);
  endtask
  task automatic idle(string tag, int qb);
    drive(tag, 2'b00, 0, 0, 3'b000, 0, 0, 0, 0, qb);
  endtask

  // monitor: results appear one edge after the inputs
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, "open_o", open_o, it.open);
      check(it.tag, "err_act_o", 32'(err_act_o), 32'(it.eact));
      check(it.tag, "err_xpre_o", 32'(err_xpre_o), 32'(it.exp_x));
      check(it.tag, "query_open_o", 32'(query_open_o), 32'(it.qopen));
      check(it.tag, "query_row_o", 32'(query_row_o), 32'(it.qrow));
    end
  end

  initial begin
    foreach (m_row[i]) begin m_row[i] = '0; m_open[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "open_o", open_o, 32'h0);
    check("R1", "err_act_o", 32'(err_act_o), 32'h0);
    check("R1", "err_xpre_o", 32'(err_xpre_o), 32'h0);
    check("R1", "query_row_o", 32'(query_row_o), 32'h0);

    xpre("R10", 0);                 // no column command yet
    act("R2", 3, 9'h1A5);
    act("R3", 3, 9'h077);           // already open, row must stay 1A5
    act("R4", 4, 9'h011);
    act("R4", 2, 9'h012);
    act("R5", 15, 9'h100);
    act("R5", 16, 9'h0FF);
    act("R5", 0, 9'h001);
    act("R5", 31, 9'h1FF);
    act("R4", 14, 9'h003);
    act("R4", 17, 9'h004);
    pre("R6", 3);
    pre("R6", 3);                   // redundant precharge
    act("R6", 4, 9'h055);
    col("R8", 3'b001, 4, 0);
    xpre("R9", 4);
    act("R2", 4, 9'h0AA);
    col("R10", 3'b010, 4, 1);
    xpre("R10", 4);
    col("R9", 3'b010, 4, 0);
    xpre("R9", 4);
    act("R2", 4, 9'h133);
    col("R10", 3'b011, 4, 0);
    xpre("R10", 4);
    col("R8", 3'b010, 4, 1);
    col("R8", 3'b011, 4, 0);
    col("R7", 3'b101, 16, 0);
    col("R7", 3'b110, 15, 1);
    col("R7", 3'b111, 0, 0);
    col("R9", 3'b001, 31, 0);
    idle("R9", 31);
    xpre("R9", 31);
    pre("R6", 4);
    idle("R1", 4);
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule